// File: doc/BRIEF.md
# ARINC-429 Single-Channel Receiver with Error Classification

This block receives one ARINC-429 channel from a pair of line-state inputs (a "high" leg and a "low" leg, as a line receiver would present them). A programmable prescaler turns the system clock into a sample strobe, with a fixed number of samples per bit time. The receiver looks at each bit's active half and takes one sample near its middle. A null lasting a full bit time marks the end of a word. Each word is then checked for three kinds of fault: the bit count is not 32, odd parity over the 32 bits fails, or the null gap before the word was too short.

Each finished word is written into a receive queue together with a timestamp, taken from an external counter input at the moment the word is closed. A faulty word still goes into the queue, but its top bit (bit 31, the parity position) is forced to 1. A three-bit cause code goes into a separate error queue, and an interrupt request stays high while that queue holds anything. Both queues are read through valid/ready streams. A loopback select lets the receiver listen to a local transmitter's output instead of the external line.

Top module: `arx_rx_top`

## Requirements
- R1: A sample strobe occurs once every `rate_div`+1 clocks, and one bit time lasts OSR strobes. A sample with only `line_hi` asserted is an active 1 and a sample with only `line_lo` asserted is an active 0. Both legs equal counts as null. The bit value is taken on the (OSR/4+1)-th consecutive active sample.
- R2: A word closes after OSR consecutive null samples. The first bit received lands in stored bit 0, the next in bit 1, and so on.
- R3: A word of exactly 32 bits whose 32 bits hold an even number of ones gets error code bit 0 (parity). Parity is not judged for words of any other length.
- R4: A word with a bit count other than 32 gets error code bit 1 (bit count). Bits after the 32nd are discarded.
- R5: The null run is counted in samples from the last active sample. If it is shorter than GAP_BITS×OSR when a new word begins, that word gets error code bit 2 (gap). A run of exactly GAP_BITS×OSR samples is accepted. The first word after reset never gets this error.
- R6: A word with any error is stored with bit 31 forced to 1 and all other bits as received. A clean word is stored unchanged.
- R7: Each stored word carries the value of `ts_in` from the cycle in which the word was closed.
- R8: Every errored word adds one entry holding its non-zero code to the error queue. A clean word adds none. Entries leave in arrival order.
- R9: `irq` is high exactly while the error queue holds at least one entry.
- R10: Both outputs are valid/ready streams. While `valid` is high and `ready` is low, `valid` and the data stay unchanged, and an entry leaves only on a cycle with both high. A word that arrives while a queue is full is dropped from that queue alone.
- R11: While `loop_en` is high, the receiver uses `loop_hi`/`loop_lo`, and `line_hi`/`line_lo` have no effect.
- R12: After reset both queues are empty and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_div | input | DIV_W | Sample strobe divider; strobe period is rate_div+1 clocks |
| loop_en | input | 1 | Select loopback legs instead of the external line |
| line_hi | input | 1 | External line, high leg |
| line_lo | input | 1 | External line, low leg |
| loop_hi | input | 1 | Loopback source, high leg |
| loop_lo | input | 1 | Loopback source, low leg |
| ts_in | input | TS_W | Timestamp counter value |
| rx_valid | output | 1 | Receive queue holds a word |
| rx_ready | input | 1 | Consumer takes the head word |
| rx_word | output | 32 | Head word, bit 31 forced to 1 on error |
| rx_ts | output | TS_W | Timestamp of the head word |
| err_valid | output | 1 | Error queue holds an entry |
| err_ready | input | 1 | Consumer takes the head error entry |
| err_code | output | 3 | Cause: bit 0 parity, bit 1 bit count, bit 2 gap |
| irq | output | 1 | Error queue not empty |

## Verification
The bench builds the block with OSR 8, GAP_BITS 4 and a queue depth of 8. A depth of 8 lets nine back-to-back words overrun the receive queue within a short run. A null run of 32 samples can be hit exactly and one sample short, so both sides of the gap boundary are covered. Most words use a divider of 0, so each clock is a sample. One word uses a divider of 3 to show that the bit timing scales with the strobe. The same small configuration also reaches the 31-bit and 33-bit word lengths and a word that carries two causes at once.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam int WORD_BITS = 32;
  localparam int CODE_BITS = 3;
  localparam int CODE_PAR  = 0;
  localparam int CODE_CNT  = 1;
  localparam int CODE_GAP  = 2;
  typedef logic [WORD_BITS-1:0] arx_word_t;
  typedef logic [CODE_BITS-1:0] arx_code_t;
endpackage

// File: rtl/arx_tick.sv
module arx_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] rate_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= rate_div);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/arx_fifo.sv
module arx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          full, do_push, do_pop;

  assign full      = (cnt == CW'(DEPTH));
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rd_ptr];
  assign do_push   = push && !full;
  assign do_pop    = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/arx_deframer.sv
module arx_deframer
  import arx_pkg::*;
#(
  parameter int OSR      = 8,
  parameter int GAP_BITS = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      leg_hi,
  input  logic      leg_lo,
  output logic      emit,
  output arx_word_t word_o,
  output arx_code_t code_o
);
  localparam int MID      = OSR / 4;
  localparam int GAP_SAMP = GAP_BITS * OSR;
  localparam int NR_W     = $clog2(GAP_SAMP + 1);
  localparam int ACT_W    = $clog2(OSR + 1);

  logic [1:0]       sync_hi, sync_lo;
  logic             act, bitv, prev_act, in_word, gap_lat, gap_word;
  logic [ACT_W-1:0] act_idx, idx_cur;
  logic [NR_W-1:0]  null_run;
  logic [5:0]       bit_cnt;
  arx_word_t        data;
  logic             cnt_bad, par_bad;
  arx_code_t        code_now;

  assign act      = sync_hi[1] ^ sync_lo[1];
  assign bitv     = sync_hi[1];
  assign idx_cur  = prev_act ? act_idx : '0;
  assign cnt_bad  = (bit_cnt != 6'd32);
  assign par_bad  = !cnt_bad && !(^data);

  always_comb begin
    code_now           = '0;
    code_now[CODE_PAR] = par_bad;
    code_now[CODE_CNT] = cnt_bad;
    code_now[CODE_GAP] = gap_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_hi <= '0;
      sync_lo <= '0;
    end else begin
      sync_hi <= {sync_hi[0], leg_hi};
      sync_lo <= {sync_lo[0], leg_lo};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_act <= 1'b0;
      act_idx  <= '0;
      null_run <= NR_W'(GAP_SAMP);
      in_word  <= 1'b0;
      bit_cnt  <= '0;
      data     <= '0;
      gap_lat  <= 1'b0;
      gap_word <= 1'b0;
      emit     <= 1'b0;
      word_o   <= '0;
      code_o   <= '0;
    end else begin
      emit <= 1'b0;
      if (tick) begin
        prev_act <= act;
        if (act) begin
          null_run <= '0;
          if (!prev_act) gap_lat <= (null_run < NR_W'(GAP_SAMP));
          if (idx_cur != ACT_W'(OSR)) act_idx <= idx_cur + 1'b1;
          if (idx_cur == ACT_W'(MID)) begin
            if (!in_word) begin
              in_word  <= 1'b1;
              bit_cnt  <= 6'd1;
              data     <= {{(WORD_BITS-1){1'b0}}, bitv};
              gap_word <= gap_lat;
            end else begin
              if (bit_cnt < 6'd32) data[bit_cnt[4:0]] <= bitv;
              if (bit_cnt != 6'd33) bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end else begin
          if (null_run != NR_W'(GAP_SAMP)) null_run <= null_run + 1'b1;
          if (in_word && null_run == NR_W'(OSR-1)) begin
            in_word <= 1'b0;
            emit    <= 1'b1;
            code_o  <= code_now;
            word_o  <= (|code_now) ? (data | {1'b1, {(WORD_BITS-1){1'b0}}}) : data;
          end
        end
      end
    end
  end
endmodule

// File: rtl/arx_rx_top.sv
module arx_rx_top
  import arx_pkg::*;
#(
  parameter int OSR      = 8,
  parameter int GAP_BITS = 4,
  parameter int DEPTH    = 16,
  parameter int DIV_W    = 8,
  parameter int TS_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] rate_div,
  input  logic             loop_en,
  input  logic             line_hi,
  input  logic             line_lo,
  input  logic             loop_hi,
  input  logic             loop_lo,
  input  logic [TS_W-1:0]  ts_in,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [31:0]      rx_word,
  output logic [TS_W-1:0]  rx_ts,
  output logic             err_valid,
  input  logic             err_ready,
  output logic [2:0]       err_code,
  output logic             irq
);
  localparam int RXW = TS_W + WORD_BITS;

  logic      tick, leg_hi, leg_lo, emit, err_push;
  arx_word_t dfr_word;
  arx_code_t dfr_code;
  logic [RXW-1:0] rx_head;

  assign leg_hi   = loop_en ? loop_hi : line_hi;
  assign leg_lo   = loop_en ? loop_lo : line_lo;
  assign err_push = emit && (|dfr_code);

  arx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .rate_div(rate_div), .tick(tick)
  );

  arx_deframer #(.OSR(OSR), .GAP_BITS(GAP_BITS)) u_dfr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .leg_hi(leg_hi), .leg_lo(leg_lo),
    .emit(emit), .word_o(dfr_word), .code_o(dfr_code)
  );

  arx_fifo #(.W(RXW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(emit), .push_data({ts_in, dfr_word}),
    .out_valid(rx_valid), .out_ready(rx_ready), .out_data(rx_head)
  );

  arx_fifo #(.W(CODE_BITS), .DEPTH(DEPTH)) u_errq (
    .clk(clk), .rst_n(rst_n), .push(err_push), .push_data(dfr_code),
    .out_valid(err_valid), .out_ready(err_ready), .out_data(err_code)
  );

  assign rx_word = rx_head[WORD_BITS-1:0];
  assign rx_ts   = rx_head[RXW-1:WORD_BITS];
  assign irq     = err_valid;
endmodule

// File: rtl/arx_rx_chk.sv
module arx_rx_chk #(
  parameter int TS_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            emit,
  input logic [31:0]     dfr_word,
  input logic [2:0]      dfr_code,
  input logic            rx_valid,
  input logic            rx_ready,
  input logic [31:0]     rx_word,
  input logic [TS_W-1:0] rx_ts,
  input logic            err_valid,
  input logic            err_ready,
  input logic [2:0]      err_code,
  input logic            irq
);
  a_r6_err_sets_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && (dfr_code != 3'b000)) |-> dfr_word[31]);

  a_r3_clean_word_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && (dfr_code == 3'b000)) |-> (^dfr_word));

  a_r8_err_code_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_code != 3'b000));

  a_r9_irq_rise_after_error: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(emit && (dfr_code != 3'b000)));

  a_r10_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_word) && $stable(rx_ts)));

  a_r10_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && !err_ready) |=> (err_valid && $stable(err_code)));
endmodule

bind arx_rx_top arx_rx_chk #(.TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .emit(emit), .dfr_word(dfr_word), .dfr_code(dfr_code),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_word(rx_word), .rx_ts(rx_ts),
  .err_valid(err_valid), .err_ready(err_ready), .err_code(err_code), .irq(irq)
);

// File: tb/arx_rx_top_test.sv
module arx_rx_top_test;
  localparam int OSR = 8, GAP_BITS = 4, DEPTH = 8, DIV_W = 8, TS_W = 16;

  typedef struct packed {
    logic [31:0] data;
    logic [5:0]  nbits;
    logic [7:0]  pre;
    logic [15:0] ts;
    logic [31:0] xword;
    logic [2:0]  xcode;
  } vec_t;

  // R2 bit order, R3 parity, R4 count, R5 gap boundary (32 ok / 31 short), R6 flag
  localparam vec_t VEC [8] = '{
    '{32'h0000_0001, 6'd32, 8'd40, 16'h0101, 32'h0000_0001, 3'b000},
    '{32'h8000_00FF, 6'd32, 8'd28, 16'h0202, 32'h8000_00FF, 3'b000},
    '{32'h0000_0003, 6'd32, 8'd40, 16'h0303, 32'h8000_0003, 3'b001},
    '{32'h0000_00AB, 6'd31, 8'd40, 16'h0404, 32'h8000_00AB, 3'b010},
    '{32'h0000_0007, 6'd32, 8'd27, 16'h0505, 32'h8000_0007, 3'b100},
    '{32'h1234_5678, 6'd33, 8'd40, 16'h0606, 32'h9234_5678, 3'b010},
    '{32'h0000_000F, 6'd32, 8'd12, 16'h0707, 32'h8000_000F, 3'b101},
    '{32'h7FFF_FFFF, 6'd32, 8'd40, 16'h0808, 32'h7FFF_FFFF, 3'b000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DIV_W-1:0] rate_div = '0;
  logic loop_en = 1'b0, line_hi = 1'b0, line_lo = 1'b0, loop_hi = 1'b0, loop_lo = 1'b0;
  logic [TS_W-1:0] ts_in = '0;
  logic rx_valid, rx_ready = 1'b0, err_valid, err_ready = 1'b0, irq;
  logic [31:0] rx_word;
  logic [TS_W-1:0] rx_ts;
  logic [2:0] err_code;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  arx_rx_top #(.OSR(OSR), .GAP_BITS(GAP_BITS), .DEPTH(DEPTH), .DIV_W(DIV_W), .TS_W(TS_W)) uut (
    .clk(clk), .rst_n(rst_n), .rate_div(rate_div), .loop_en(loop_en),
    .line_hi(line_hi), .line_lo(line_lo), .loop_hi(loop_hi), .loop_lo(loop_lo),
    .ts_in(ts_in), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_word(rx_word),
    .rx_ts(rx_ts), .err_valid(err_valid), .err_ready(err_ready), .err_code(err_code),
    .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic samp(input logic h, input logic l, input int n);
    for (int i = 0; i < n * (int'(rate_div) + 1); i++) begin
      @(negedge clk);
      if (loop_en) begin
        loop_hi = h; loop_lo = l; line_hi = 1'b1; line_lo = 1'b0;
      end else begin
        line_hi = h; line_lo = l;
      end
    end
  endtask

  task automatic send(input logic [31:0] data, input int nbits, input int pre, input logic [15:0] ts);
    samp(1'b0, 1'b0, pre);
    ts_in = ts;
    for (int i = 0; i < nbits; i++) begin
      logic b;
      b = (i < 32) ? data[i] : 1'b1;
      samp(b, !b, OSR/2);
      samp(1'b0, 1'b0, OSR/2);
    end
  endtask

  task automatic pop_rx(input logic [31:0] xw, input logic [15:0] xts, input string req);
    @(negedge clk);
    check(rx_valid === 1'b1, req, 64'(rx_valid), 64'd1);
    check(rx_word === xw, req, 64'(rx_word), 64'(xw));
    check(rx_ts === xts, {req, " R7"}, 64'(rx_ts), 64'(xts));
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic pop_err(input logic [2:0] xc);
    @(negedge clk);
    check(err_valid === 1'b1 && err_code === xc, "R8 error queue entry", 64'(err_code), 64'(xc));
    err_ready = 1'b1;
    @(negedge clk);
    err_ready = 1'b0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    logic [31:0] held;
    repeat (5) @(negedge clk);
    check(rx_valid === 1'b0, "R12 rx queue empty", 64'(rx_valid), 64'd0);
    check(err_valid === 1'b0, "R12 err queue empty", 64'(err_valid), 64'd0);
    check(irq === 1'b0, "R12 irq low", 64'(irq), 64'd0);
    rst_n = 1'b1;

    // table walk: all words queued, then drained in order
    foreach (VEC[k]) send(VEC[k].data, int'(VEC[k].nbits), int'(VEC[k].pre), VEC[k].ts);
    samp(1'b0, 1'b0, 40);
    repeat (6) @(negedge clk);
    check(irq === 1'b1, "R9 irq with errors queued", 64'(irq), 64'd1);
    held = rx_word;
    repeat (4) @(negedge clk);
    check(rx_valid === 1'b1 && rx_word === held, "R10 head held without ready", 64'(rx_word), 64'(held));
    foreach (VEC[k]) pop_rx(VEC[k].xword, VEC[k].ts, $sformatf("R2/R3/R4/R5/R6 vector %0d", k));
    check(rx_valid === 1'b0, "R10 rx queue drained", 64'(rx_valid), 64'd0);
    foreach (VEC[k]) if (VEC[k].xcode != 3'b000) pop_err(VEC[k].xcode);
    @(negedge clk);
    check(err_valid === 1'b0, "R8 no entries for clean words", 64'(err_valid), 64'd0);
    check(irq === 1'b0, "R9 irq low once drained", 64'(irq), 64'd0);

    // R10: overrun, nine words into a depth-8 queue
    for (int i = 0; i < 9; i++) send(32'h1 << i, 32, 40, 16'h1000 + 16'(i));
    samp(1'b0, 1'b0, 40);
    repeat (6) @(negedge clk);
    for (int i = 0; i < 8; i++) pop_rx(32'h1 << i, 16'h1000 + 16'(i), "R10 overrun keeps first eight");
    check(rx_valid === 1'b0, "R10 ninth word dropped", 64'(rx_valid), 64'd0);
    check(irq === 1'b0, "R8 clean overrun words log no error", 64'(irq), 64'd0);

    // R11: loopback, external line held active and must be ignored
    loop_en = 1'b1;
    send(32'h0000_0100, 32, 40, 16'h2222);
    samp(1'b0, 1'b0, 40);
    repeat (6) @(negedge clk);
    pop_rx(32'h0000_0100, 16'h2222, "R11 loopback word");
    check(rx_valid === 1'b0, "R11 line ignored", 64'(rx_valid), 64'd0);
    line_hi = 1'b0; line_lo = 1'b0;
    samp(1'b0, 1'b0, 4);
    loop_en = 1'b0;
    samp(1'b0, 1'b0, 40);

    // R1: slower strobe, each sample spans four clocks
    rate_div = 8'd3;
    send(32'h0000_0010, 32, 40, 16'h3333);
    samp(1'b0, 1'b0, 40);
    repeat (10) @(negedge clk);
    pop_rx(32'h0000_0010, 16'h3333, "R1 divided strobe");
    check(err_valid === 1'b0, "R1 divided strobe no error", 64'(err_valid), 64'd0);

    done = 1'b1;
    report();
  end
endmodule